// File: doc/BRIEF.md
# Decade Counter with Selectable Early Clear

A four-bit up-counter that advances by one on every clock edge where its count-enable input is high. It runs through the decimal digits 0 to 9 and then returns to 0000. The bit pattern is read directly as a binary value, with bit 3 as the most significant bit.

Two clear-request levels, called tap A and tap B, are each taken from a configurable source. A source can be one bit of the count, a constant high or a constant low. When both levels are high, the counter clears. This shortens the count to a smaller modulus: tapping bit 3 gives a repeating 0 to 7 sequence. Tapping bits 0 and 1 together stops the count at 0010.

The clear is synchronous. The taps are decoded on the value the counter is about to take. If both taps are high on that value, the counter loads 0000 instead, so the value that triggers the clear never appears at the output. A terminal-count flag marks the enabled cycle in which the counter wraps to 0000.

Top module: `bcd_cutoff_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0000 and stays there. The terminal-count flag `tc` is low whenever `cnt_en` is low.
- R2: When `cnt_en` is low, the count keeps its value at every clock edge.
- R3: With both tap selects set to 7 (held low), the counter runs 0,1,…,9 and then 0, advancing one step per enabled edge (modulus 10).
- R4: `tc` is high in exactly those cycles where `cnt_en` is high and the next count will be 0000. One enabled edge later, the count reads 0000.
- R5: Tap select coding, applied to each of `tap_a` and `tap_b`: 0, 1, 2 and 3 pick that bit of the candidate next count; 4 gives a constant high; 5, 6 and 7 give a constant low.
- R6: When both tap levels are high on the candidate next count, the counter loads 0000 instead. The triggering value never appears on `count`. For example, taps 3 and 4 give a modulus-8 sequence.
- R7: Taps 0 and 1 give the sequence 0,1,2 (modulus 3). Taps 1 and 2 give 0 to 5 (modulus 6). The order of the two taps does not matter.
- R8: With both taps at 4, the count stays at 0000 and `tc` is high on every enabled cycle.
- R9: `count` never exceeds 9. A tap pair whose clear pattern lies above 9, such as bits 3 and 1, leaves the modulus at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous global reset, active high |
| cnt_en | input | 1 | Count-enable pulse; one step per high cycle |
| tap_a | input | 3 | Source select for the first clear-request level |
| tap_b | input | 3 | Source select for the second clear-request level |
| count | output | 4 | Current count, bit 3 most significant |
| tc | output | 1 | High in the enabled cycle that wraps the count to 0000 |

## Verification
The bench walks nine tap configurations over two full periods each, comparing against moduli 10, 8, 6, 3, 2 and 1.

A design that decoded the current count instead of the next count would show the clearing value for one step, so modulus 8 would visit 8. The bench would then see a nonzero count where it expects 0. A design that treated tap 4 as low would never truncate when paired with a single bit, so the count would run on past 7. A design that decoded an unreachable pattern such as 1010 would cut the decade short.

Idle cycles with `cnt_en` low and a reset in mid-count check that the flag stays quiet and the count holds or clears as required.

// File: rtl/bcd_cutoff_counter.sv
`timescale 1ns/1ps
module bcd_cutoff_counter #(
  parameter int W    = 4,
  parameter int LAST = 9,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cnt_en,
  input  logic [SELW-1:0] tap_a,
  input  logic [SELW-1:0] tap_b,
  output logic [W-1:0]    count,
  output logic            tc
);
  localparam logic [SELW-1:0] SEL_HIGH = SELW'(W);
  localparam logic [W-1:0]    LAST_V   = W'(LAST);

  function automatic logic tap_level(input logic [SELW-1:0] sel, input logic [W-1:0] v);
    logic lvl;
    lvl = (sel == SEL_HIGH);
    for (int i = 0; i < W; i++)
      if (sel == SELW'(i)) lvl = v[i];
    return lvl;
  endfunction

  logic [W-1:0] step, nxt;

  assign step = (count == LAST_V) ? '0 : count + 1'b1;
  assign nxt  = (tap_level(tap_a, step) && tap_level(tap_b, step)) ? '0 : step;
  assign tc   = cnt_en && (nxt == '0);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (cnt_en) count <= nxt;
  end
endmodule

// File: rtl/bcd_cutoff_counter_chk.sv
`timescale 1ns/1ps
module bcd_cutoff_counter_chk #(
  parameter int W    = 4,
  parameter int LAST = 9,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            cnt_en,
  input logic [SELW-1:0] tap_a,
  input logic [SELW-1:0] tap_b,
  input logic [W-1:0]    count,
  input logic            tc
);
  function automatic logic lv(input logic [SELW-1:0] s, input logic [W-1:0] v);
    if (s > SELW'(W)) return 1'b0;
    if (s == SELW'(W)) return 1'b1;
    return v[s[$clog2(W)-1:0]];
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> count == '0);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !cnt_en |=> $stable(count));
  // R4
  tc_wrap_chk: assert property (@(posedge clk) disable iff (rst) tc |=> count == '0);
  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !tc) |=> count == $past(count) + 1'b1);
  // R1
  tc_idle_chk: assert property (@(posedge clk) disable iff (rst) !cnt_en |-> !tc);
  // R9
  range_chk: assert property (@(posedge clk) disable iff (rst) count <= W'(LAST));
  // R6
  trunc_absent_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (count == '0) || !(lv($past(tap_a), count) && lv($past(tap_b), count)));
endmodule

bind bcd_cutoff_counter bcd_cutoff_counter_chk #(.W(W), .LAST(LAST), .SELW(SELW)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .tap_a(tap_a), .tap_b(tap_b),
  .count(count), .tc(tc));

// File: tb/bcd_cutoff_counter_test.sv
`timescale 1ns/1ps
module bcd_cutoff_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [2:0] tap_a = 3'd7;
  logic [2:0] tap_b = 3'd7;
  logic [3:0] count;
  logic       tc;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bcd_cutoff_counter uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .tap_a(tap_a), .tap_b(tap_b),
    .count(count), .tc(tc));

  // {tap_a, tap_b, expected modulus}
  localparam logic [9:0] VEC [9] = '{
    {3'd7, 3'd7, 4'd10},  // R3 no truncation
    {3'd3, 3'd4, 4'd8},   // R6 bit3 + held high
    {3'd4, 3'd3, 4'd8},   // R7 order swapped
    {3'd0, 3'd1, 4'd3},   // R7 stop at 0010
    {3'd1, 3'd2, 4'd6},   // R7 stop at 0101
    {3'd1, 3'd4, 4'd2},   // R5 single bit
    {3'd4, 3'd4, 4'd1},   // R8 both high
    {3'd3, 3'd1, 4'd10},  // R9 pattern above nine
    {3'd5, 3'd6, 4'd10}   // R5 held low codes
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cnt_en = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset tc", int'(tc), 0);

    for (int v = 0; v < 9; v++) begin
      int modv;
      int exp;
      modv = int'(VEC[v][3:0]);
      @(negedge clk);
      tap_a = VEC[v][9:7];
      tap_b = VEC[v][6:4];
      do_reset();
      exp = 0;
      for (int s = 0; s < 2 * modv + 1; s++) begin
        cnt_en = 1'b1;
        #1;
        chk($sformatf("R4 tc vec%0d step%0d", v, s), int'(tc), (exp == modv - 1) ? 1 : 0);
        @(negedge clk);
        exp = (exp + 1 == modv) ? 0 : exp + 1;
        chk($sformatf("R6 R7 count vec%0d step%0d", v, s), int'(count), exp);
      end
      cnt_en = 1'b0;
    end

    // R2 idle hold
    tap_a = 3'd7; tap_b = 3'd7;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      cnt_en = 1'b1; @(negedge clk);
    end
    cnt_en = 1'b0;
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      chk("R2 hold count", int'(count), 4);
      chk("R1 tc idle", int'(tc), 0);
    end
    // R2 hold at nine, then wrap
    for (int s = 0; s < 5; s++) begin
      cnt_en = 1'b1; @(negedge clk);
    end
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 hold at nine", int'(count), 9);
    chk("R4 tc idle at nine", int'(tc), 0);
    cnt_en = 1'b1; #1;
    chk("R4 tc at nine", int'(tc), 1);
    @(negedge clk);
    chk("R3 wrap from nine", int'(count), 0);
    // R1 reset in mid-count
    for (int s = 0; s < 3; s++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset", int'(count), 0);
    rst = 1'b0; cnt_en = 1'b0;
    @(negedge clk);
    chk("R1 after reset", int'(count), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule